// File: doc/BRIEF.md
# SPI Status Flag Controller

This block keeps the three status flags of an SPI peripheral and enforces the two-step handshake that clears each one. Software reaches it through a small register bus with an address, a read strobe, a write strobe and write data. The bus selects one of three registers: status, data and the first control register. A status read shows the flags. A later access to the matching register completes the handshake and clears the flag. A data write that was not prepared by such a status read is dropped.

The shift engine reports two events. One says a received byte has landed in the data register. The other says the buffered transmit byte has been taken for shifting. The slave-select level, the master-mode level and the mode-fault detection enable come in as plain inputs. The block drives the status byte and a one-cycle strobe with the byte accepted for transmission. It also drives three interrupt requests, each gated by its own enable.

Top module: `spi_flag_ctrl`

## Requirements
- R1: The status byte carries the receive-full flag at bit 7, the transmit-empty flag at bit 5 and the mode-fault flag at bit 4. Bits 6, 3, 2, 1 and 0 always read 0. The bus addresses are 0 for control register 1, 3 for status and 5 for data.
- R2: After reset the status byte is 0x20, so only transmit-empty is set. The accept strobe is low and the accepted-byte output is 0x00.
- R3: A bus write to address 3 changes no flag.
- R4: A receive-loaded event sets the receive-full flag, and the flag is visible in the next cycle.
- R5: The receive-full flag clears only when a status read that returned it as 1 is followed by a read of address 5. A data read without that earlier status read leaves the flag set.
- R6: A status read that returned transmit-empty as 1, followed by a write to address 5, clears transmit-empty in the next cycle. In that same next cycle the block raises the accept strobe for exactly one cycle and presents the written byte.
- R7: A write to address 5 that was not prepared by a status read showing transmit-empty as 1 produces no accept strobe. It leaves the flag and the accepted-byte output unchanged.
- R8: The mode-fault flag sets in the cycle after a clock edge that samples slave-select low while master mode and mode-fault detection are both 1. It does not set when either of them is 0.
- R9: The mode-fault flag clears only when a status read that returned it as 1 is followed by a write to address 0.
- R10: Each flag has its own arm bit, loaded on every status read with the value the read returned. The arm bit is consumed by that flag's own clearing access, or it is reloaded by the next status read. Accesses to other registers leave it as it is.
- R11: When a flag's set event comes in the same cycle as its armed clearing access, the flag stays set.
- R12: A transmit-taken event sets transmit-empty again. Each interrupt request equals its flag ANDed with its enable input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_addr_i | input | 3 | Register address (0 control 1, 3 status, 5 data) |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_wdata_i | input | 8 | Write data |
| rx_loaded_i | input | 1 | Shift engine moved a received byte into the data register |
| tx_taken_i | input | 1 | Shift engine took the buffered transmit byte |
| ss_n_i | input | 1 | Slave-select pin level, active low |
| master_i | input | 1 | Block is configured as master |
| fault_det_en_i | input | 1 | Mode-fault detection enable |
| irq_rx_en_i | input | 1 | Receive-full interrupt enable |
| irq_tx_en_i | input | 1 | Transmit-empty interrupt enable |
| irq_fault_en_i | input | 1 | Mode-fault interrupt enable |
| status_o | output | 8 | Status byte |
| tx_accept_o | output | 1 | One-cycle strobe: a data write was accepted |
| tx_data_o | output | 8 | Byte accepted by the last armed data write |
| irq_rx_o | output | 1 | Receive-full interrupt request |
| irq_tx_o | output | 1 | Transmit-empty interrupt request |
| irq_fault_o | output | 1 | Mode-fault interrupt request |

## Verification
Several rules are checked by the bound properties on every cycle. The reserved status bits must stay zero, and each set event must show its flag in the following cycle. Every accept strobe must trace back to a data write made while transmit-empty was showing, with the same byte. A flag may fall only after its own clearing access, and a status write must leave the flags alone. The interrupt outputs must equal their gated flags. The arming itself can only be shown by the bench's scenarios. These cover status reads taken while a flag was still clear, reloading by a second status read, unrelated accesses between the two steps, and set events that collide with a clearing access. In each case the per-cycle reference model decides the expected flag values.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

    localparam int unsigned NUM_FLAGS = 3;
    localparam int unsigned STAT_W    = 8;

    // flag slots inside the per-flag arrays
    localparam int unsigned FLG_RX = 0;
    localparam int unsigned FLG_TX = 1;
    localparam int unsigned FLG_MF = 2;

    // status byte positions, decoded by software
    localparam int unsigned FLAG_BIT [NUM_FLAGS] = '{7, 5, 4};

    // reset value per slot: only transmit-empty starts set
    localparam logic [NUM_FLAGS-1:0] FLAG_RST = 3'b010;

    typedef struct packed {
        logic flag;
        logic arm;
    } cell_state_t;

    typedef struct packed {
        logic stat_rd;
        logic data_rd;
        logic data_wr;
        logic ctrl1_wr;
    } bus_evt_t;

    typedef struct packed {
        logic       valid;
        logic [7:0] data;
    } hold_state_t;

endpackage

// File: rtl/spi_flag_decode.sv
module spi_flag_decode
    import spi_flag_pkg::*;
#(
    parameter int unsigned        ADDR_W   = 3,
    parameter logic [ADDR_W-1:0]  A_CTRL1  = 'd0,
    parameter logic [ADDR_W-1:0]  A_STATUS = 'd3,
    parameter logic [ADDR_W-1:0]  A_DATA   = 'd5
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              rd_i,
    input  logic              wr_i,
    output bus_evt_t          evt_o
);

    logic hit_ctrl1;
    logic hit_status;
    logic hit_data;

    always_comb begin
        hit_ctrl1  = (addr_i == A_CTRL1);
        hit_status = (addr_i == A_STATUS);
        hit_data   = (addr_i == A_DATA);

        evt_o          = '0;
        evt_o.stat_rd  = rd_i & hit_status;
        evt_o.data_rd  = rd_i & hit_data;
        evt_o.data_wr  = wr_i & hit_data;
        evt_o.ctrl1_wr = wr_i & hit_ctrl1;
        // status writes decode to nothing: they must leave the flags alone
    end

endmodule

// File: rtl/spi_flag_cell.sv
module spi_flag_cell
    import spi_flag_pkg::*;
#(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic capture_i,   // status read: load arm from current flag
    input  logic access_i,    // second-step access for this flag
    input  logic set_i,       // hardware set event
    output logic flag_o,
    output logic clear_o      // armed second step taken this cycle
);

    cell_state_t st_d;
    cell_state_t st_q;

    always_comb begin
        st_d    = st_q;
        clear_o = access_i & st_q.arm;

        if (capture_i) begin
            st_d.arm = st_q.flag;
        end else if (access_i) begin
            st_d.arm = 1'b0;
        end

        if (set_i) begin
            st_d.flag = 1'b1;
        end else if (clear_o) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q.flag <= RST_VAL;
            st_q.arm  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_o = st_q.flag;

endmodule

// File: rtl/spi_flag_txhold.sv
module spi_flag_txhold
    import spi_flag_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              take_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              strobe_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hd_d;
    hold_t hd_q;

    always_comb begin
        hd_d       = hd_q;
        hd_d.valid = take_i;
        if (take_i) begin
            hd_d.data = wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hd_q <= '0;
        end else begin
            hd_q <= hd_d;
        end
    end

    assign strobe_o = hd_q.valid;
    assign data_o   = hd_q.data;

endmodule

// File: rtl/spi_flag_ctrl.sv
module spi_flag_ctrl
    import spi_flag_pkg::*;
#(
    parameter int unsigned       ADDR_W   = 3,
    parameter int unsigned       DATA_W   = 8,
    parameter logic [ADDR_W-1:0] A_CTRL1  = 'd0,
    parameter logic [ADDR_W-1:0] A_STATUS = 'd3,
    parameter logic [ADDR_W-1:0] A_DATA   = 'd5
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_rd_i,
    input  logic              bus_wr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              rx_loaded_i,
    input  logic              tx_taken_i,
    input  logic              ss_n_i,
    input  logic              master_i,
    input  logic              fault_det_en_i,
    input  logic              irq_rx_en_i,
    input  logic              irq_tx_en_i,
    input  logic              irq_fault_en_i,
    output logic [STAT_W-1:0] status_o,
    output logic              tx_accept_o,
    output logic [DATA_W-1:0] tx_data_o,
    output logic              irq_rx_o,
    output logic              irq_tx_o,
    output logic              irq_fault_o
);

    bus_evt_t             evt;
    logic                 fault_hit;
    logic [NUM_FLAGS-1:0] cell_access;
    logic [NUM_FLAGS-1:0] cell_set;
    logic [NUM_FLAGS-1:0] cell_flag;
    logic [NUM_FLAGS-1:0] cell_clear;

    spi_flag_decode #(
        .ADDR_W   (ADDR_W),
        .A_CTRL1  (A_CTRL1),
        .A_STATUS (A_STATUS),
        .A_DATA   (A_DATA)
    ) decode_i (
        .addr_i (bus_addr_i),
        .rd_i   (bus_rd_i),
        .wr_i   (bus_wr_i),
        .evt_o  (evt)
    );

    // slave-select pulled low while driving as master with detection on
    assign fault_hit = master_i & fault_det_en_i & ~ss_n_i;

    always_comb begin
        cell_access         = '0;
        cell_set            = '0;
        cell_access[FLG_RX] = evt.data_rd;
        cell_access[FLG_TX] = evt.data_wr;
        cell_access[FLG_MF] = evt.ctrl1_wr;
        cell_set[FLG_RX]    = rx_loaded_i;
        cell_set[FLG_TX]    = tx_taken_i;
        cell_set[FLG_MF]    = fault_hit;
    end

    for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_cell
        spi_flag_cell #(
            .RST_VAL (FLAG_RST[g])
        ) cell_i (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .capture_i (evt.stat_rd),
            .access_i  (cell_access[g]),
            .set_i     (cell_set[g]),
            .flag_o    (cell_flag[g]),
            .clear_o   (cell_clear[g])
        );
    end

    spi_flag_txhold #(
        .DATA_W (DATA_W)
    ) txhold_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .take_i   (cell_clear[FLG_TX]),
        .wdata_i  (bus_wdata_i),
        .strobe_o (tx_accept_o),
        .data_o   (tx_data_o)
    );

    always_comb begin
        status_o = '0;
        for (int i = 0; i < int'(NUM_FLAGS); i++) begin
            status_o[FLAG_BIT[i]] = cell_flag[i];
        end
    end

    assign irq_rx_o    = cell_flag[FLG_RX] & irq_rx_en_i;
    assign irq_tx_o    = cell_flag[FLG_TX] & irq_tx_en_i;
    assign irq_fault_o = cell_flag[FLG_MF] & irq_fault_en_i;

endmodule

// File: rtl/spi_flag_ctrl_chk.sv
module spi_flag_ctrl_chk #(
    parameter int unsigned       ADDR_W   = 3,
    parameter int unsigned       DATA_W   = 8,
    parameter logic [ADDR_W-1:0] A_CTRL1  = 'd0,
    parameter logic [ADDR_W-1:0] A_STATUS = 'd3,
    parameter logic [ADDR_W-1:0] A_DATA   = 'd5
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_rd_i,
    input logic              bus_wr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              rx_loaded_i,
    input logic              tx_taken_i,
    input logic              ss_n_i,
    input logic              master_i,
    input logic              fault_det_en_i,
    input logic              irq_rx_en_i,
    input logic              irq_tx_en_i,
    input logic              irq_fault_en_i,
    input logic [7:0]        status_o,
    input logic              tx_accept_o,
    input logic [DATA_W-1:0] tx_data_o,
    input logic              irq_rx_o,
    input logic              irq_tx_o,
    input logic              irq_fault_o
);

    logic fault_cond;
    assign fault_cond = master_i & fault_det_en_i & ~ss_n_i;

    p_reserved_zero_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (status_o & 8'h4F) == 8'h00);

    p_status_wr_inert_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_wr_i && bus_addr_i == A_STATUS && !rx_loaded_i && !tx_taken_i && !fault_cond)
        |=> $stable(status_o));

    p_rx_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rx_loaded_i |=> status_o[7]);

    p_rx_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(status_o[7]) |-> $past(bus_rd_i && bus_addr_i == A_DATA));

    p_accept_byte_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_accept_o |-> tx_data_o == $past(bus_wdata_i));

    p_accept_origin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_accept_o |-> $past(bus_wr_i && bus_addr_i == A_DATA && status_o[5]));

    p_fault_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fault_cond |=> status_o[4]);

    p_fault_fall_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(status_o[4]) |-> $past(bus_wr_i && bus_addr_i == A_CTRL1));

    p_tx_set_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tx_taken_i |=> status_o[5]);

    p_irq_gate_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_rx_o == (status_o[7] & irq_rx_en_i)) &&
        (irq_tx_o == (status_o[5] & irq_tx_en_i)) &&
        (irq_fault_o == (status_o[4] & irq_fault_en_i)));

endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .A_CTRL1  (A_CTRL1),
    .A_STATUS (A_STATUS),
    .A_DATA   (A_DATA)
) chk_i (.*);

// File: tb/spi_flag_ctrl_tb_top.sv
`timescale 1ns/1ps
module spi_flag_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = 3'd0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       rxl = 1'b0;
    logic       txt = 1'b0;
    logic       ss_n = 1'b1;
    logic       mst = 1'b0;
    logic       fen = 1'b0;
    logic       en_rx = 1'b0;
    logic       en_tx = 1'b0;
    logic       en_mf = 1'b0;

    logic [7:0] status;
    logic       acc;
    logic [7:0] tdata;
    logic       irq_rx;
    logic       irq_tx;
    logic       irq_mf;

    always #2 clk = ~clk;

    spi_flag_ctrl dut_i (
        .clk_i          (clk),
        .rst_ni         (rst_n),
        .bus_addr_i     (addr),
        .bus_rd_i       (rd),
        .bus_wr_i       (wr),
        .bus_wdata_i    (wdata),
        .rx_loaded_i    (rxl),
        .tx_taken_i     (txt),
        .ss_n_i         (ss_n),
        .master_i       (mst),
        .fault_det_en_i (fen),
        .irq_rx_en_i    (en_rx),
        .irq_tx_en_i    (en_tx),
        .irq_fault_en_i (en_mf),
        .status_o       (status),
        .tx_accept_o    (acc),
        .tx_data_o      (tdata),
        .irq_rx_o       (irq_rx),
        .irq_tx_o       (irq_tx),
        .irq_fault_o    (irq_mf)
    );

    // behavioural reference state
    int m_rx, m_tx, m_mf;
    int a_rx, a_tx, a_mf;
    int m_acc, m_data;
    int n_compared = 0;
    int n_bad = 0;
    string cur_req = "R1";
    bit done = 0;

    task automatic check(string req, string what, int act, int expv);
        n_compared++;
        if (act != expv) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, expv, $time);
        end
    endtask

    function automatic int model_status();
        return m_rx * 128 + m_tx * 32 + m_mf * 16;
    endfunction

    task automatic model_reset();
        m_rx = 0; m_tx = 1; m_mf = 0;
        a_rx = 0; a_tx = 0; a_mf = 0;
        m_acc = 0; m_data = 0;
    endtask

    // compare now, advance model and design by one clock, clear pulses
    task automatic tick();
        int s_rd, d_rd, d_wr, c_wr, fault, take;
        int n_rx, n_tx, n_mf, n_arx, n_atx, n_amf;
        #1;
        check(cur_req, "status", status, model_status());
        check(cur_req, "accept", acc, m_acc);
        check(cur_req, "tx_data", tdata, m_data);
        check("R12", "irq_rx", irq_rx, m_rx & en_rx);
        check("R12", "irq_tx", irq_tx, m_tx & en_tx);
        check("R12", "irq_fault", irq_mf, m_mf & en_mf);

        s_rd  = (rd && addr == 3) ? 1 : 0;
        d_rd  = (rd && addr == 5) ? 1 : 0;
        d_wr  = (wr && addr == 5) ? 1 : 0;
        c_wr  = (wr && addr == 0) ? 1 : 0;
        fault = (mst && fen && !ss_n) ? 1 : 0;
        take  = d_wr & a_tx;

        n_rx = rxl ? 1 : ((d_rd && a_rx) ? 0 : m_rx);
        n_tx = txt ? 1 : (take ? 0 : m_tx);
        n_mf = fault ? 1 : ((c_wr && a_mf) ? 0 : m_mf);
        n_arx = s_rd ? m_rx : (d_rd ? 0 : a_rx);
        n_atx = s_rd ? m_tx : (d_wr ? 0 : a_tx);
        n_amf = s_rd ? m_mf : (c_wr ? 0 : a_mf);

        @(posedge clk);
        m_rx = n_rx; m_tx = n_tx; m_mf = n_mf;
        a_rx = n_arx; a_tx = n_atx; a_mf = n_amf;
        m_acc = take;
        if (take != 0) m_data = wdata;
        @(negedge clk);
        rd = 0; wr = 0; rxl = 0; txt = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask
    task automatic stat_read();
        addr = 3'd3; rd = 1; tick();
    endtask
    task automatic data_read();
        addr = 3'd5; rd = 1; tick();
    endtask
    task automatic data_write(logic [7:0] b);
        addr = 3'd5; wr = 1; wdata = b; tick();
    endtask
    task automatic ctrl1_write(logic [7:0] b);
        addr = 3'd0; wr = 1; wdata = b; tick();
    endtask
    task automatic stat_write(logic [7:0] b);
        addr = 3'd3; wr = 1; wdata = b; tick();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired t=%0t", $time);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_compared, n_bad);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        check("R2", "reset status", status, 8'h20);
        check("R2", "reset accept", acc, 0);
        check("R2", "reset tx_data", tdata, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R2 state held after release, all enables off
        cur_req = "R2";
        idle(2);

        // R3: writes to status address change nothing
        cur_req = "R3";
        stat_write(8'hFF);
        stat_write(8'h00);
        idle(1);

        // R7: unarmed data write is dropped
        cur_req = "R7";
        data_write(8'h3C);
        idle(2);

        // R6: armed write accepted, strobe next cycle with byte
        cur_req = "R6";
        stat_read();
        data_write(8'hA5);
        idle(2);
        // R7: arm consumed, second write dropped
        cur_req = "R7";
        data_write(8'h5A);
        idle(1);
        // R7: status read while transmit-empty is 0 does not arm
        stat_read();
        data_write(8'h77);
        idle(1);

        // R12: transmit-taken sets transmit-empty again, irq gating
        cur_req = "R12";
        en_tx = 1;
        txt = 1; tick();
        idle(2);
        en_tx = 0;
        idle(1);

        // R4 / R5
        cur_req = "R4";
        rxl = 1; tick();
        idle(1);
        cur_req = "R5";
        data_read();           // unarmed: stays set
        idle(1);
        stat_read();
        data_read();           // armed: clears
        idle(2);

        // R10: arm loaded while flag was 0 does not clear later
        cur_req = "R10";
        stat_read();           // rx is 0 here
        rxl = 1; tick();
        data_read();           // arm was 0: flag stays
        idle(1);
        // R10: unrelated access between steps keeps arm
        stat_read();
        ctrl1_write(8'h11);
        stat_write(8'h00);
        data_read();           // clears
        idle(1);
        // R10: second status read reloads arm with current value
        rxl = 1; tick();
        stat_read();
        stat_read();
        data_read();           // still armed (flag was 1 both times)
        idle(1);

        // R11: set event collides with armed clear
        cur_req = "R11";
        rxl = 1; tick();
        stat_read();
        addr = 3'd5; rd = 1; rxl = 1; tick();
        idle(1);
        stat_read();
        data_read();
        idle(1);
        stat_read();           // tx is 1 here
        addr = 3'd5; wr = 1; wdata = 8'hC3; txt = 1; tick();
        idle(2);

        // R8: fault only with master and detection both set
        cur_req = "R8";
        mst = 1; fen = 0; ss_n = 0; tick();
        ss_n = 1; idle(1);
        mst = 0; fen = 1; ss_n = 0; tick();
        ss_n = 1; idle(1);
        en_mf = 1;
        mst = 1; fen = 1; ss_n = 0; tick();
        ss_n = 1; idle(1);

        // R9: ctrl1 write unarmed keeps flag, armed clears
        cur_req = "R9";
        ctrl1_write(8'h40);
        idle(1);
        stat_read();
        data_read();           // wrong register, arm for fault kept
        ctrl1_write(8'h50);
        idle(2);
        // R11 for fault: slave-select low during armed ctrl1 write
        cur_req = "R11";
        ss_n = 0; tick();
        ss_n = 1;
        stat_read();
        addr = 3'd0; wr = 1; ss_n = 0; tick();
        ss_n = 1; idle(1);
        stat_read();
        ctrl1_write(8'h00);
        idle(1);

        // R12: all interrupt gates together
        cur_req = "R12";
        en_rx = 1; en_tx = 1; en_mf = 1;
        rxl = 1; tick();
        idle(1);
        en_rx = 0;
        idle(1);

        // R1: reserved bits stay 0 with all flags set
        cur_req = "R1";
        mst = 1; fen = 1; ss_n = 0; tick();
        ss_n = 1; mst = 0; fen = 0;
        idle(1);
        #1;
        check("R1", "reserved bits", status & 8'h4F, 0);
        check("R1", "all flags", status, 8'hB0);
        @(negedge clk);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_compared, n_bad);
        $finish;
    end

endmodule